// File: doc/BRIEF.md
# Two-Clock Scan Chain with Crossing Latch

This block is a test-mode register chain made of multiplexed-input scan flip-flops. Its cells are split between two clock domains, called the source domain (A) and the sink domain (B). A single scan-enable input sets the mode for every cell. When it is low, one clock edge loads the parallel functional inputs into the cells. When it is high, the cells form one serial shift register that runs from the scan input, through all of domain A and then all of domain B, to the scan output. The functional logic around the registers is not part of the block. It appears only as parallel data inputs and the parallel register outputs.

The sink clock may arrive later than the source clock. To keep shifting safe under that skew, a level-sensitive holding latch sits between the last source cell and the first sink cell. The latch is open while the source clock is low and closed while it is high. It therefore holds back the value of the last source cell for half a cycle. With this latch, the sink's first cell takes the old value of the last source cell even when the sink edge comes after the source edge, provided the skew is below half a period. The latch does not add a bit position to the chain.

Top module: `xdom_scan_chain`

## Requirements
- R1: While `rstAN` is low at a rising edge of `clkA`, every domain A cell is cleared to 0 at that edge. While `rstAN` is low and `clkA` is low, the crossing latch drives 0.
- R2: While `rstBN` is low at a rising edge of `clkB`, every domain B cell is cleared to 0 at that edge.
- R3: With `scanEn` = 0, a rising edge of a domain's clock loads that domain's functional input into its cells. Bit i of `funcInA` goes to `regOutA[i]`, and bit i of `funcInB` goes to `regOutB[i]`.
- R4: With `scanEn` = 1, each edge moves every cell one place along the chain: `regOutA[0]` takes `scanIn`, and `regOutA[i]` takes the old `regOutA[i-1]`. The same holds inside domain B. `funcInA` and `funcInB` have no effect.
- R5: The crossing latch is transparent while `clkA` is low and holds while `clkA` is high. `regOutB[0]` shifts in the value that `regOutA[LEN_A-1]` held before the `clkA` edge of the same cycle, even when `clkB` lags `clkA` by less than half a period.
- R6: A bit applied at `scanIn` for shift cycle 1 appears at `scanOut` after exactly LEN_A+LEN_B shift edges. The latch adds no position.
- R7: `scanOut` always equals the last domain B cell, `regOutB[LEN_B-1]`. Bit 0 of domain A is the cell nearest `scanIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Source-domain clock |
| clkB | input | 1 | Sink-domain clock (may lag clkA) |
| rstAN | input | 1 | Synchronous active-low reset for domain A and the crossing latch |
| rstBN | input | 1 | Synchronous active-low reset for domain B |
| scanEn | input | 1 | 1 = serial shift, 0 = functional capture |
| scanIn | input | 1 | Serial input into domain A bit 0 |
| scanOut | output | 1 | Serial output from domain B last bit |
| funcInA | input | LEN_A | Functional data for domain A cells |
| funcInB | input | LEN_B | Functional data for domain B cells |
| regOutA | output | LEN_A | Domain A cell contents |
| regOutB | output | LEN_B | Domain B cell contents |

## Verification
The assertions check the local behaviour of each segment on every cycle: clear on reset, one-place shift, and parallel load. They also check that the latch has followed its input by the time the source clock rises. Only the bench scenarios can show the end-to-end chain behaviour. These scenarios run with the sink clock lagging by 1.5 ns. They show that the sink takes the old source value across the crossing, and that the total latency is exactly LEN_A+LEN_B edges. They also show that a source-side reset clears the latch before the sink samples it, and that functional inputs are ignored while shifting.

// File: rtl/xdom_scan_pkg.sv
package xdom_scan_pkg;

  // Per-domain strobes from control to a register segment; exactly one is high.
  typedef struct packed {
    logic clear;
    logic shift;
    logic capture;
  } segStrobeT;

endpackage

// File: rtl/xdom_scan_ctrl.sv
module xdom_scan_ctrl
  import xdom_scan_pkg::*;
(
  input  logic      rstN,
  input  logic      scanEn,
  output segStrobeT strobe
);

  // Reset wins over both modes; otherwise scanEn picks shift or capture.
  always_comb begin
    strobe.clear   = ~rstN;
    strobe.shift   = rstN & scanEn;
    strobe.capture = rstN & ~scanEn;
  end

endmodule

// File: rtl/xdom_scan_seg.sv
module xdom_scan_seg
  import xdom_scan_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  segStrobeT        strobe,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] cells,
  output logic             serOut
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftNext;

  // Bit 0 is nearest the serial input.
  always_comb shiftNext = (cells << 1) | WIDTH'(serIn);

  always_ff @(posedge clk) begin
    if (strobe.clear)      cells <= '0;
    else if (strobe.shift) cells <= shiftNext;
    else                   cells <= parIn;
  end

  assign serOut = cells[LAST];

  // R1 (domain A) / R2 (domain B): a clear strobe empties the segment
  p_clear_r1: assert property (@(posedge clk)
    strobe.clear |=> cells == '0);

  // R4: the first cell takes the serial input
  p_shift_head_r4: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.shift |=> cells[0] == $past(serIn));

  generate
    if (WIDTH > 1) begin : g_body
      // R4: every other cell takes its neighbour's old value
      p_shift_body_r4: assert property (@(posedge clk) disable iff (strobe.clear)
        strobe.shift |=> cells[LAST:1] == $past(cells[LAST-1:0]));
    end
  endgenerate

  // R3: capture loads the parallel inputs
  p_capture_r3: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.capture |=> cells == $past(parIn));

endmodule

// File: rtl/xdom_scan_lockup.sv
module xdom_scan_lockup (
  input  logic srcClk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  // Open during the low phase of the source clock, closed during the high phase.
  always_latch begin
    if (!srcClk) q = rstN ? d : 1'b0;
  end

  // R5: after a full low phase the latch matches the last source cell at the edge
  p_follow_r5: assert property (@(posedge srcClk) disable iff (!rstN)
    q == d);

endmodule

// File: rtl/xdom_scan_chain.sv
module xdom_scan_chain
  import xdom_scan_pkg::*;
#(
  parameter int LEN_A = 3,
  parameter int LEN_B = 4
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstAN,
  input  logic             rstBN,
  input  logic             scanEn,
  input  logic             scanIn,
  output logic             scanOut,
  input  logic [LEN_A-1:0] funcInA,
  input  logic [LEN_B-1:0] funcInB,
  output logic [LEN_A-1:0] regOutA,
  output logic [LEN_B-1:0] regOutB
);

  segStrobeT strobeA, strobeB;
  logic      tailA, latchQ, tailB;

  xdom_scan_ctrl u_ctrlA (.rstN(rstAN), .scanEn(scanEn), .strobe(strobeA));
  xdom_scan_ctrl u_ctrlB (.rstN(rstBN), .scanEn(scanEn), .strobe(strobeB));

  xdom_scan_seg #(.WIDTH(LEN_A)) u_segA (
    .clk(clkA), .strobe(strobeA), .serIn(scanIn), .parIn(funcInA),
    .cells(regOutA), .serOut(tailA));

  xdom_scan_lockup u_lock (.srcClk(clkA), .rstN(rstAN), .d(tailA), .q(latchQ));

  xdom_scan_seg #(.WIDTH(LEN_B)) u_segB (
    .clk(clkB), .strobe(strobeB), .serIn(latchQ), .parIn(funcInB),
    .cells(regOutB), .serOut(tailB));

  // R7: serial output is the final sink cell
  assign scanOut = tailB;

endmodule

// File: tb/tb_xdom_scan_chain.sv
`timescale 1ns/1ps
module tb_xdom_scan_chain;

  localparam int LA = 3;
  localparam int LB = 4;
  localparam int LT = LA + LB;

  logic clkA, clkB, rstAN, rstBN, scanEn, scanIn, scanOut;
  logic [LA-1:0] funcInA, regOutA;
  logic [LB-1:0] funcInB, regOutB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xdom_scan_chain #(.LEN_A(LA), .LEN_B(LB)) dut (
    .clkA(clkA), .clkB(clkB), .rstAN(rstAN), .rstBN(rstBN),
    .scanEn(scanEn), .scanIn(scanIn), .scanOut(scanOut),
    .funcInA(funcInA), .funcInB(funcInB),
    .regOutA(regOutA), .regOutB(regOutB));

  // 200 MHz; sink clock lags by 1.5 ns (under half a period)
  initial begin clkA = 0; forever #2.5 clkA = ~clkA; end
  initial begin clkB = 0; #1.5; forever #2.5 clkB = ~clkB; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected chain state: bits [LA-1:0] domain A, [LT-1:LA] domain B.
  logic [LT-1:0] model;

  task automatic checkModel(input string req);
    chk(req, 32'(regOutA), 32'(model[LA-1:0]));
    chk(req, 32'(regOutB), 32'(model[LT-1:LA]));
    chk({req, " R7"}, 32'(scanOut), 32'(model[LT-1]));
  endtask

  task automatic capture(input logic [LT-1:0] v);
    scanEn = 0; funcInA = v[LA-1:0]; funcInB = v[LT-1:LA];
    @(negedge clkA);
    model = v;
  endtask

  task automatic shiftOne(input logic b, input logic [LT-1:0] junk);
    scanEn = 1; scanIn = b; funcInA = junk[LA-1:0]; funcInB = junk[LT-1:LA];
    @(negedge clkA);
    model = {model[LT-2:0], b};
  endtask

  initial begin
    rstAN = 0; rstBN = 0; scanEn = 0; scanIn = 1;
    funcInA = '1; funcInB = '1; model = '0;
    repeat (3) @(negedge clkA);
    // R1 R2: reset clears everything despite nonzero functional inputs
    chk("R1 reset A", 32'(regOutA), 0);
    chk("R2 reset B", 32'(regOutB), 0);
    chk("R2 reset scanOut", 32'(scanOut), 0);
    rstAN = 1; rstBN = 1;

    // R3: exhaustive capture sweep
    for (int v = 0; v < (1 << LT); v++) begin
      capture(LT'(v));
      checkModel("R3 capture");
    end

    // R4 R5: shift from every start state, functional inputs toggling
    for (int p = 0; p < (1 << LT); p++) begin
      logic [LT-1:0] pat;
      pat = LT'(p) ^ LT'(7'h55);
      capture(LT'(p));
      for (int k = 0; k < LT; k++) begin
        shiftOne(pat[k], ~LT'(p + k));
        checkModel("R4 shift");
      end
    end

    // R6: single marker bit takes exactly LT edges
    capture('0);
    for (int n = 1; n <= LT + 1; n++) begin
      shiftOne(n == 1, '1);
      chk("R6 latency", 32'(scanOut), 32'(n == LT));
    end

    // R5: old last-A value crosses into B0 under skew
    capture(LT'(1 << (LA - 1)));
    shiftOne(1'b0, '0);
    chk("R5 crossing B0", 32'(regOutB[0]), 1);
    chk("R5 crossing A", 32'(regOutA), 0);

    // R1: source reset clears the latch before the sink samples it
    capture(LT'(1 << (LA - 1)));
    scanEn = 1; scanIn = 0; rstAN = 0;
    @(negedge clkA);
    rstAN = 1;
    chk("R1 latch reset B0", 32'(regOutB[0]), 0);
    chk("R1 reset A during shift", 32'(regOutA), 0);

    // R2: sink reset alone, source keeps shifting
    capture({4'b1111, 3'b101});
    scanEn = 1; scanIn = 1; rstBN = 0;
    @(negedge clkA);
    rstBN = 1;
    chk("R2 reset B only", 32'(regOutB), 0);
    chk("R2 A still shifts", 32'(regOutA), 32'(3'b011));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clkA);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule